// File: doc/BRIEF.md
# Adaptive Transmit Start Threshold

This block sits between a transmit FIFO and the logic that begins sending a frame on the medium. It grants permission to start a frame once either a programmable number of bytes is buffered or the whole frame is already in the FIFO, whichever happens first. The threshold is held as a level counted in 64-byte units. A DMA engine fills the FIFO in fixed-size bursts, so the level has a hard ceiling of (FIFO bytes minus burst bytes) / 64. Above that ceiling the FIFO could never gain enough free space for the next burst, and the transmitter would stall.

The level adapts at run time. Any reported underrun (FIFO, data or delimiter) raises it by one step. A decrement strobe lowers it by one step, but not below a programmable floor. No adjustment of either kind is accepted once the level has reached the programmed maximum. A one-cycle pulse marks every adjustment that was actually applied, so a refused request can be told apart from an accepted one.

A small register port reads and writes the level, the maximum and the minimum. Written values are clamped, so an unsafe setting cannot be programmed. Once a frame is granted, the permission is latched until that frame has drained. A level change during the frame therefore cannot withdraw the grant.

Top module: `tx_start_thresh`

## Requirements
- R1: After reset the level is 1, the maximum equals the ceiling (6 with the default 512-byte FIFO and 128-byte bursts), the minimum is 1, and start_ok_o and lvl_chg_o are low.
- R2: When start_ok_o is low and occ_i is at least level × 64 in a cycle, start_ok_o is high from the next cycle. With occ_i one byte below that value and no whole frame buffered, it stays low.
- R3: When start_ok_o is low and frame_buffered_i is high, start_ok_o rises in the next cycle whatever the occupancy.
- R4: Once high, start_ok_o stays high, whatever the occupancy or level changes, until a cycle with frame_end_i high; it is low in the cycle after. A frame_end_i pulse while start_ok_o is low has no effect.
- R5: In a cycle with no register write, if any bit of underrun_i is set (bit 0 FIFO, bit 1 data, bit 2 delimiter) and level < maximum, the level rises by exactly one, however many bits are set. lvl_chg_o is high for that one cycle, the cycle in which the new level is visible.
- R6: An underrun while level ≥ maximum leaves the level unchanged and gives no lvl_chg_o pulse.
- R7: lvl_dec_i lowers the level by one, with a lvl_chg_o pulse, when minimum < level < maximum. At level ≤ minimum it has no effect.
- R8: lvl_dec_i is refused while level ≥ maximum. This includes the case where the maximum has been written below the current level.
- R9: A write to the maximum stores the written value, limited to the range from the current minimum up to the ceiling (FIFO_BYTES − BURST_BYTES) / 64.
- R10: A write to the level is clamped into [minimum, maximum]. A write to the minimum is clamped into [1, maximum]. In a write cycle no strobe adjustment is applied and no lvl_chg_o pulse follows.
- R11: When an underrun and lvl_dec_i arrive in the same cycle, only the increment is applied.
- R12: cfg_rdata_o is combinational from cfg_addr_i: address 0 reads the level, 1 the maximum, 2 the minimum, 3 reads zero. cfg_addr_i uses the same encoding to select the target of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| occ_i | input | $clog2(FIFO_BYTES+1) | FIFO occupancy in bytes |
| frame_buffered_i | input | 1 | Whole current frame is in the FIFO |
| frame_end_i | input | 1 | Last byte of the granted frame has left the FIFO |
| underrun_i | input | N_UND | Underrun strobes: bit 0 FIFO, bit 1 data, bit 2 delimiter |
| lvl_dec_i | input | 1 | Request to lower the level by one |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 2 | Register select: 0 level, 1 maximum, 2 minimum |
| cfg_wdata_i | input | LVL_W | Register write data |
| cfg_rdata_o | output | LVL_W | Register read data |
| start_ok_o | output | 1 | Permission to start transmitting the current frame |
| lvl_chg_o | output | 1 | One-cycle pulse after an applied level adjustment |

## Verification
The hardest case to reach from the ports is the refusal of a decrement whose level lies within the normal range, because the level sits at or above a maximum that was lowered after the level climbed. The stimulus first drives the level to the ceiling with a train of underrun strobes. It then writes a smaller maximum and issues decrements and underruns, which must all be refused. A grant is also opened with a whole-frame indication, and underruns are applied while it is held, so that a level change lands in the middle of a frame. A long random phase follows, mixing clamped writes, strobe collisions and frame boundaries, all compared with the bench's reference model.

// File: rtl/tx_start_thresh_pkg.sv
package tx_start_thresh_pkg;

  typedef enum logic [1:0] {
    SEL_LEVEL = 2'd0,
    SEL_MAX   = 2'd1,
    SEL_MIN   = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  typedef enum logic {
    GATE_WAIT = 1'b0,
    GATE_OPEN = 1'b1
  } gate_e;

endpackage

// File: rtl/txst_level_regs.sv
module txst_level_regs
  import tx_start_thresh_pkg::*;
#(
  parameter int LVL_W = 8,
  parameter int CEIL  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [LVL_W-1:0] cfg_wdata_i,
  output logic [LVL_W-1:0] cfg_rdata_o,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [LVL_W-1:0] level_o,
  output logic [LVL_W-1:0] max_o,
  output logic [LVL_W-1:0] min_o,
  output logic             chg_o
);

  localparam logic [LVL_W-1:0] CeilV = LVL_W'(CEIL);
  localparam logic [LVL_W-1:0] OneV  = LVL_W'(1);

  logic [LVL_W-1:0] level_q, level_d;
  logic [LVL_W-1:0] max_q, max_d;
  logic [LVL_W-1:0] min_q, min_d;
  logic             chg_q;
  logic             adj_open, do_inc, do_dec;
  cfg_sel_e         sel;

  function automatic logic [LVL_W-1:0] clamp_f(input logic [LVL_W-1:0] v,
                                               input logic [LVL_W-1:0] lo,
                                               input logic [LVL_W-1:0] hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  assign sel      = cfg_sel_e'(cfg_addr_i);
  // adjustments of either direction are refused once the level reaches max
  assign adj_open = level_q < max_q;
  assign do_inc   = !cfg_we_i && inc_i && adj_open;
  assign do_dec   = !cfg_we_i && !inc_i && dec_i && adj_open && (level_q > min_q);

  always_comb begin
    level_d = level_q;
    max_d   = max_q;
    min_d   = min_q;
    if (cfg_we_i) begin
      unique case (sel)
        SEL_LEVEL: level_d = clamp_f(cfg_wdata_i, min_q, max_q);
        SEL_MAX:   max_d   = clamp_f(cfg_wdata_i, min_q, CeilV);
        SEL_MIN:   min_d   = clamp_f(cfg_wdata_i, OneV, max_q);
        default:   ;
      endcase
    end else if (do_inc) begin
      level_d = level_q + OneV;
    end else if (do_dec) begin
      level_d = level_q - OneV;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= OneV;
      max_q   <= CeilV;
      min_q   <= OneV;
      chg_q   <= 1'b0;
    end else begin
      level_q <= level_d;
      max_q   <= max_d;
      min_q   <= min_d;
      chg_q   <= do_inc | do_dec;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_LEVEL: cfg_rdata_o = level_q;
      SEL_MAX:   cfg_rdata_o = max_q;
      SEL_MIN:   cfg_rdata_o = min_q;
      default:   cfg_rdata_o = '0;
    endcase
  end

  assign level_o = level_q;
  assign max_o   = max_q;
  assign min_o   = min_q;
  assign chg_o   = chg_q;

endmodule

// File: rtl/txst_start_gate.sv
module txst_start_gate
  import tx_start_thresh_pkg::*;
#(
  parameter int LVL_W      = 8,
  parameter int OCC_W      = 10,
  parameter int UNIT_SHIFT = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OCC_W-1:0] occ_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             frame_buffered_i,
  input  logic             frame_end_i,
  output logic             start_ok_o
);

  localparam int CMP_W = (OCC_W > LVL_W + UNIT_SHIFT) ? OCC_W : LVL_W + UNIT_SHIFT;

  logic [CMP_W-1:0] thr_bytes;
  logic [CMP_W-1:0] occ_ext;
  logic             enough;
  gate_e            state_q, state_d;

  assign thr_bytes = CMP_W'({level_i, {UNIT_SHIFT{1'b0}}});
  assign occ_ext   = CMP_W'(occ_i);
  assign enough    = (occ_ext >= thr_bytes) || frame_buffered_i;

  // grant latched per frame; the level is consulted only while waiting
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GATE_WAIT: if (enough)      state_d = GATE_OPEN;
      GATE_OPEN: if (frame_end_i) state_d = GATE_WAIT;
      default:                    state_d = GATE_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= GATE_WAIT;
    else         state_q <= state_d;
  end

  assign start_ok_o = (state_q == GATE_OPEN);

endmodule

// File: rtl/tx_start_thresh.sv
module tx_start_thresh #(
  parameter int FIFO_BYTES  = 512,
  parameter int BURST_BYTES = 128,
  parameter int UNIT_SHIFT  = 6,
  parameter int LVL_W       = 8,
  parameter int N_UND       = 3,
  localparam int OCC_W      = $clog2(FIFO_BYTES + 1),
  localparam int CEIL       = (FIFO_BYTES - BURST_BYTES) >> UNIT_SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OCC_W-1:0] occ_i,
  input  logic             frame_buffered_i,
  input  logic             frame_end_i,
  input  logic [N_UND-1:0] underrun_i,
  input  logic             lvl_dec_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [LVL_W-1:0] cfg_wdata_i,
  output logic [LVL_W-1:0] cfg_rdata_o,
  output logic             start_ok_o,
  output logic             lvl_chg_o
);

  logic [LVL_W-1:0] level_w;
  logic [LVL_W-1:0] max_w;
  logic [LVL_W-1:0] min_w;
  logic             inc_req;

  // several underrun kinds in one cycle still count as one step
  assign inc_req = |underrun_i;

  txst_level_regs #(
    .LVL_W(LVL_W),
    .CEIL (CEIL)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o),
    .inc_i      (inc_req),
    .dec_i      (lvl_dec_i),
    .level_o    (level_w),
    .max_o      (max_w),
    .min_o      (min_w),
    .chg_o      (lvl_chg_o)
  );

  txst_start_gate #(
    .LVL_W     (LVL_W),
    .OCC_W     (OCC_W),
    .UNIT_SHIFT(UNIT_SHIFT)
  ) u_gate (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .occ_i           (occ_i),
    .level_i         (level_w),
    .frame_buffered_i(frame_buffered_i),
    .frame_end_i     (frame_end_i),
    .start_ok_o      (start_ok_o)
  );

endmodule

// File: rtl/txst_checker.sv
module txst_checker #(
  parameter int LVL_W = 8,
  parameter int CEIL  = 6,
  parameter int N_UND = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_UND-1:0] underrun_i,
  input logic             lvl_dec_i,
  input logic             cfg_we_i,
  input logic             frame_buffered_i,
  input logic             frame_end_i,
  input logic             start_ok_o,
  input logic             lvl_chg_o,
  input logic [LVL_W-1:0] level_i,
  input logic [LVL_W-1:0] max_i,
  input logic [LVL_W-1:0] min_i
);

  assert_limits_order_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_i <= LVL_W'(CEIL)) && (min_i >= LVL_W'(1)) && (min_i <= max_i));

  assert_inc_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|underrun_i && !cfg_we_i && level_i < max_i)
      |=> (level_i == $past(level_i) + LVL_W'(1)) && lvl_chg_o);

  assert_refuse_at_max_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && level_i >= max_i) |=> $stable(level_i) && !lvl_chg_o);

  assert_dec_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && !(|underrun_i) && lvl_dec_i && level_i <= min_i)
      |=> $stable(level_i) && !lvl_chg_o);

  assert_write_no_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !lvl_chg_o);

  assert_whole_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_ok_o && frame_buffered_i) |=> start_ok_o);

  assert_grant_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_ok_o && !frame_end_i) |=> start_ok_o);

  assert_grant_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_ok_o && frame_end_i) |=> !start_ok_o);

endmodule

bind tx_start_thresh txst_checker #(
  .LVL_W(LVL_W),
  .CEIL (CEIL),
  .N_UND(N_UND)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .underrun_i      (underrun_i),
  .lvl_dec_i       (lvl_dec_i),
  .cfg_we_i        (cfg_we_i),
  .frame_buffered_i(frame_buffered_i),
  .frame_end_i     (frame_end_i),
  .start_ok_o      (start_ok_o),
  .lvl_chg_o       (lvl_chg_o),
  .level_i         (level_w),
  .max_i           (max_w),
  .min_i           (min_w)
);

// File: tb/tx_start_thresh_tb.sv
`timescale 1ns/1ps
module tx_start_thresh_tb;

  localparam int OCC_W = 10;
  localparam int LVL_W = 8;
  localparam int CEIL  = 6;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [OCC_W-1:0] occ = '0;
  logic             fbuf = 1'b0;
  logic             fend = 1'b0;
  logic [2:0]       und = '0;
  logic             dec = 1'b0;
  logic             we = 1'b0;
  logic [1:0]       addr = '0;
  logic [LVL_W-1:0] wdata = '0;
  logic [LVL_W-1:0] rdata;
  logic             start_ok;
  logic             chg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  tx_start_thresh u_dut (
    .clk_i           (clk),
    .rst_ni          (rst_ni),
    .occ_i           (occ),
    .frame_buffered_i(fbuf),
    .frame_end_i     (fend),
    .underrun_i      (und),
    .lvl_dec_i       (dec),
    .cfg_we_i        (we),
    .cfg_addr_i      (addr),
    .cfg_wdata_i     (wdata),
    .cfg_rdata_o     (rdata),
    .start_ok_o      (start_ok),
    .lvl_chg_o       (chg)
  );

  // behavioural reference model
  int m_lvl, m_max, m_min, m_start, m_chg;

  function automatic int clampi(int v, int lo, int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_lvl = 1; m_max = CEIL; m_min = 1; m_start = 0; m_chg = 0;
    end else begin
      int nchg;
      nchg = 0;
      if (m_start != 0) begin
        if (fend) m_start = 0;
      end else if (fbuf || int'(occ) >= m_lvl * 64) begin
        m_start = 1;
      end
      if (we) begin
        case (addr)
          2'd0: m_lvl = clampi(int'(wdata), m_min, m_max);
          2'd1: m_max = clampi(int'(wdata), m_min, CEIL);
          2'd2: m_min = clampi(int'(wdata), 1, m_max);
          default: ;
        endcase
      end else if (und != 0) begin
        if (m_lvl < m_max) begin m_lvl = m_lvl + 1; nchg = 1; end
      end else if (dec) begin
        if (m_lvl < m_max && m_lvl > m_min) begin m_lvl = m_lvl - 1; nchg = 1; end
      end
      m_chg = nchg;
    end
  end

  function automatic int m_rd(logic [1:0] a);
    case (a)
      2'd0: return m_lvl;
      2'd1: return m_max;
      2'd2: return m_min;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk("R4", "start_ok vs model", int'(start_ok), m_start);
      chk("R5", "lvl_chg vs model", int'(chg), m_chg);
      chk("R12", "rdata vs model", int'(rdata), m_rd(addr));
    end
  end

  task automatic cyc();
    @(posedge clk);
    #3;
  endtask

  task automatic wr(logic [1:0] a, int d);
    we = 1'b1; addr = a; wdata = LVL_W'(d);
    cyc();
    we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic strobe(logic [2:0] u, logic d);
    und = u; dec = d;
    cyc();
    und = '0; dec = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #3 rst_ni = 1'b1;
    cyc();

    // R1 reset state, R12 read map
    chk("R1", "start_ok", int'(start_ok), 0);
    chk("R1", "lvl_chg", int'(chg), 0);
    rd(2'd0, v); chk("R1", "level", v, 1);
    rd(2'd1, v); chk("R1", "max", v, CEIL);
    rd(2'd2, v); chk("R1", "min", v, 1);
    rd(2'd3, v); chk("R12", "addr3", v, 0);
    addr = 2'd0;

    // R2 threshold at level 1
    occ = 10'd63; cyc(); chk("R2", "63B lvl1", int'(start_ok), 0);
    occ = 10'd64; cyc(); chk("R2", "64B lvl1", int'(start_ok), 1);
    occ = 10'd0;  cyc(); chk("R4", "hold empty", int'(start_ok), 1);
    fend = 1'b1;  cyc(); fend = 1'b0; chk("R4", "release", int'(start_ok), 0);
    cyc(); chk("R4", "stays low", int'(start_ok), 0);
    fend = 1'b1;  cyc(); fend = 1'b0; chk("R4", "end ignored", int'(start_ok), 0);

    // R3 whole frame, then mid-frame underruns (R5, R4)
    fbuf = 1'b1; cyc(); fbuf = 1'b0; chk("R3", "whole frame", int'(start_ok), 1);
    strobe(3'b001, 1'b0);
    chk("R5", "pulse", int'(chg), 1);
    rd(2'd0, v); chk("R5", "level 2", v, 2);
    chk("R4", "mid-frame hold", int'(start_ok), 1);
    strobe(3'b110, 1'b0);
    rd(2'd0, v); chk("R5", "two kinds one step", v, 3);
    cyc(); chk("R5", "pulse one cycle", int'(chg), 0);
    fend = 1'b1; cyc(); fend = 1'b0; chk("R4", "release2", int'(start_ok), 0);

    // R2 threshold at level 3
    occ = 10'd191; cyc(); chk("R2", "191B lvl3", int'(start_ok), 0);
    occ = 10'd192; cyc(); chk("R2", "192B lvl3", int'(start_ok), 1);
    occ = 10'd0; fend = 1'b1; cyc(); fend = 1'b0;

    // R11 collision, R7 decrement
    strobe(3'b001, 1'b1);
    rd(2'd0, v); chk("R11", "inc wins", v, 4);
    chk("R11", "pulse", int'(chg), 1);
    strobe(3'b000, 1'b1);
    rd(2'd0, v); chk("R7", "dec", v, 3);

    // climb to ceiling, R6 and R8 refusals
    strobe(3'b100, 1'b0); strobe(3'b010, 1'b0); strobe(3'b001, 1'b0);
    rd(2'd0, v); chk("R5", "at ceiling", v, 6);
    strobe(3'b001, 1'b0);
    rd(2'd0, v); chk("R6", "no inc at max", v, 6);
    chk("R6", "no pulse", int'(chg), 0);
    strobe(3'b000, 1'b1);
    rd(2'd0, v); chk("R8", "no dec at max", v, 6);
    chk("R8", "no pulse", int'(chg), 0);

    // R9 maximum clamp, then lowered below level
    wr(2'd1, 200); rd(2'd1, v); chk("R9", "max clamp", v, CEIL);
    wr(2'd1, 4);   rd(2'd1, v); chk("R9", "max 4", v, 4);
    strobe(3'b000, 1'b1);
    rd(2'd0, v); chk("R8", "dec refused above max", v, 6);
    chk("R8", "no pulse above max", int'(chg), 0);
    strobe(3'b001, 1'b0);
    rd(2'd0, v); chk("R6", "inc refused above max", v, 6);

    // R10 write clamps
    wr(2'd1, 6);
    wr(2'd0, 0); rd(2'd0, v); chk("R10", "level low clamp", v, 1);
    wr(2'd0, 9); rd(2'd0, v); chk("R10", "level high clamp", v, 6);
    wr(2'd2, 9); rd(2'd2, v); chk("R10", "min high clamp", v, 6);
    wr(2'd1, 2); rd(2'd1, v); chk("R9", "max floor at min", v, 6);
    wr(2'd2, 0); rd(2'd2, v); chk("R10", "min low clamp", v, 1);
    wr(2'd0, 3);
    strobe(3'b000, 1'b1); rd(2'd0, v); chk("R7", "dec to 2", v, 2);
    strobe(3'b000, 1'b1); rd(2'd0, v); chk("R7", "dec to 1", v, 1);
    strobe(3'b000, 1'b1); rd(2'd0, v); chk("R7", "floor", v, 1);
    chk("R7", "floor no pulse", int'(chg), 0);
    und = 3'b001; wr(2'd0, 2); und = '0;
    chk("R10", "write cycle no pulse", int'(chg), 0);
    rd(2'd0, v); chk("R10", "write beats underrun", v, 2);

    // random mix compared against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      occ  = OCC_W'($urandom_range(0, 520));
      fbuf = ($urandom_range(0, 15) == 0);
      fend = ($urandom_range(0, 7) == 0);
      und  = ($urandom_range(0, 5) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
      dec  = ($urandom_range(0, 4) == 0);
      we   = ($urandom_range(0, 11) == 0);
      addr = 2'($urandom_range(0, 3));
      wdata = LVL_W'($urandom_range(0, 12));
      cyc();
    end
    we = 1'b0; und = '0; dec = 1'b0; fbuf = 1'b0; fend = 1'b0;
    cyc();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule